// File: doc/BRIEF.md
# Byte-Serial Accumulator Instruction Sequencer

This block is a small multi-cycle processor core built around two 8-bit accumulators (A and B), a 16-bit program counter and a zero/carry flag pair. It reads its program and data one byte at a time over a synchronous memory port. The port takes a 16-bit address and returns the addressed byte one cycle after the read request. The core decodes a fixed set of single-byte opcodes covering clear, increment, load, add, subtract, store and an unconditional relative branch. Their operands are reached through inherent, immediate, zero-page, full 16-bit and PC-relative addressing.

The program counter advances once for every byte read from the instruction stream, whether that byte is an opcode or an operand. Each instruction therefore takes as many fetch cycles as it has bytes, plus one read of memory data where the mode needs one. After reset, the sequencer loads the program counter from a start-address input and begins fetching there. A byte that matches no known opcode is skipped as a one-byte no-op, and a single-cycle flag is raised on an output.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is held, mem_rd and mem_wr are 0 and acc_a, acc_b, zero_flag and carry_flag read 0. The first memory read after reset release is issued at the address given on boot_addr.
- R2: Every byte of the instruction stream is read at the current program counter, and the counter then advances by one. An instruction of n bytes issues exactly n consecutive stream reads, followed by at most one data read at its effective address.
- R3: Opcode 0x4F sets A to 0, and opcode 0x5C adds 1 to B. Both are one byte long.
- R4: Opcode 0x86 loads A from the byte after the opcode. Opcode 0xB6 loads A from a 16-bit address. A load clears carry and sets zero when the loaded value is 0.
- R5: Opcodes 0x8B (immediate), 0x9B (zero-page) and 0xBB (16-bit address) add the operand to A. Carry is set to the carry out of bit 7.
- R6: Opcode 0x80 subtracts the immediate byte from A. Carry is set when a borrow occurs, that is when A was below the operand.
- R7: In zero-page mode, the single operand byte is the low address byte and the high address byte is 0x00.
- R8: In 16-bit address mode, the first operand byte is the high address byte and the second is the low byte.
- R9: Opcode 0xB7 writes A to a 16-bit address with a single one-cycle write pulse. It leaves A, B and both flags unchanged, and a read and a write are never requested in the same cycle.
- R10: Opcode 0x20 adds its signed 8-bit offset to the address of the byte after the offset. An offset of 0xFE therefore loops on the branch itself, and the bytes that are jumped over are never read.
- R11: Any opcode outside R3–R10 consumes one byte and changes no register or flag. It raises bad_opcode for exactly one cycle.
- R12: Zero and carry change only on clear A, increment B, load, add and subtract. Clear A leaves zero=1 and carry=0. Increment B sets zero from the result and sets carry when B wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_addr | input | 16 | Program start address taken after reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read request; data expected on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Write data (accumulator A) |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry/borrow flag |
| bad_opcode | output | 1 | One-cycle pulse on an undefined opcode |

## Verification
The properties assume that memory answers every read with its byte on mem_rdata in the cycle right after mem_rd. They also assume that boot_addr holds steady while reset is asserted. Because the core has no wait states, a late answer would be taken as the wrong byte. The bench meets this by using a memory model that registers its read data on the same edge that samples the request. Programs are loaded only while reset is held, and every program ends in a self-branch, so no run fetches past its last byte.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int DW = 8;
  localparam int AW = 2 * DW;

  localparam logic [DW-1:0] OPC_CLRA     = 8'h4F;
  localparam logic [DW-1:0] OPC_INCB     = 8'h5C;
  localparam logic [DW-1:0] OPC_LDA_IMM  = 8'h86;
  localparam logic [DW-1:0] OPC_LDA_EXT  = 8'hB6;
  localparam logic [DW-1:0] OPC_ADDA_IMM = 8'h8B;
  localparam logic [DW-1:0] OPC_ADDA_DIR = 8'h9B;
  localparam logic [DW-1:0] OPC_ADDA_EXT = 8'hBB;
  localparam logic [DW-1:0] OPC_SUBA_IMM = 8'h80;
  localparam logic [DW-1:0] OPC_STA_EXT  = 8'hB7;
  localparam logic [DW-1:0] OPC_BRA      = 8'h20;

  typedef enum logic [2:0] {
    S_BOOT, S_FETCH, S_DECODE, S_OPD1, S_OPD2, S_EXEC
  } seq_state_t;

  typedef enum logic [2:0] {
    M_INH, M_IMM, M_DIR, M_EXT, M_REL
  } amode_t;

  typedef enum logic [2:0] {
    A_NONE, A_CLRA, A_INCB, A_LDA, A_ADDA, A_SUBA, A_STA, A_BRA
  } aluop_t;

  typedef struct packed {
    amode_t mode;
    aluop_t op;
    logic   undef;
  } dec_t;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output dec_t          dec
);

  always_comb begin
    dec.mode  = M_INH;
    dec.op    = A_NONE;
    dec.undef = 1'b0;
    case (opcode)
      OPC_CLRA:     dec.op = A_CLRA;
      OPC_INCB:     dec.op = A_INCB;
      OPC_LDA_IMM:  begin dec.op = A_LDA;  dec.mode = M_IMM; end
      OPC_LDA_EXT:  begin dec.op = A_LDA;  dec.mode = M_EXT; end
      OPC_ADDA_IMM: begin dec.op = A_ADDA; dec.mode = M_IMM; end
      OPC_ADDA_DIR: begin dec.op = A_ADDA; dec.mode = M_DIR; end
      OPC_ADDA_EXT: begin dec.op = A_ADDA; dec.mode = M_EXT; end
      OPC_SUBA_IMM: begin dec.op = A_SUBA; dec.mode = M_IMM; end
      OPC_STA_EXT:  begin dec.op = A_STA;  dec.mode = M_EXT; end
      OPC_BRA:      begin dec.op = A_BRA;  dec.mode = M_REL; end
      default:      dec.undef = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
(
  input  aluop_t        op,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          zero
);

  logic [DW:0] wide;

  always_comb begin
    case (op)
      A_CLRA:  wide = '0;
      A_INCB:  wide = {1'b0, b_in} + {{DW{1'b0}}, 1'b1};
      A_LDA:   wide = {1'b0, operand};
      A_ADDA:  wide = {1'b0, a_in} + {1'b0, operand};
      A_SUBA:  wide = {1'b0, a_in} - {1'b0, operand};
      default: wide = {1'b0, a_in};
    endcase
  end

  assign result = wide[DW-1:0];
  assign carry  = wide[DW];
  assign zero   = (wide[DW-1:0] == '0);

endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import acc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dec_t       dec,
  output seq_state_t state_q
);

  seq_state_t state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_BOOT:   state_d = S_FETCH;
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: state_d = (dec.mode == M_INH) ? S_FETCH : S_OPD1;
      S_OPD1: begin
        case (dec.mode)
          M_DIR:   state_d = S_EXEC;
          M_EXT:   state_d = S_OPD2;
          default: state_d = S_FETCH;
        endcase
      end
      S_OPD2:   state_d = (dec.op == A_STA) ? S_FETCH : S_EXEC;
      S_EXEC:   state_d = S_FETCH;
      default:  state_d = S_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_BOOT;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] boot_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_a,
  output logic [DW-1:0] acc_b,
  output logic          zero_flag,
  output logic          carry_flag,
  output logic          bad_opcode
);

  localparam int PAGE_W = AW - DW;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t    state_q;
  dec_t          dec;
  logic [DW-1:0] op_byte;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, a_q, b_q, hi_q;
  logic          z_q, c_q, bad_q;
  logic          pc_en, ir_en, hi_en, a_en, b_en, flag_en, exec_en, bad_d;
  logic [DW-1:0] alu_res;
  logic          alu_c, alu_z;

  assign op_byte = (state_q == S_DECODE) ? mem_rdata : ir_q;

  acc_seq_decode u_dec (
    .opcode (op_byte),
    .dec    (dec)
  );

  acc_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dec     (dec),
    .state_q (state_q)
  );

  acc_seq_alu u_alu (
    .op      (dec.op),
    .a_in    (a_q),
    .b_in    (b_q),
    .operand (mem_rdata),
    .result  (alu_res),
    .carry   (alu_c),
    .zero    (alu_z)
  );

  // bus and sequencing actions per state
  always_comb begin
    mem_addr = pc_q;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    pc_d     = pc_q;
    pc_en    = 1'b0;
    ir_en    = 1'b0;
    hi_en    = 1'b0;
    exec_en  = 1'b0;
    bad_d    = 1'b0;
    case (state_q)
      S_BOOT: begin
        pc_d  = boot_addr;
        pc_en = 1'b1;
      end
      S_FETCH: begin
        mem_rd = 1'b1;
        pc_d   = pc_q + {{(AW-1){1'b0}}, 1'b1};
        pc_en  = 1'b1;
      end
      S_DECODE: begin
        ir_en = 1'b1;
        if (dec.mode == M_INH) begin
          exec_en = 1'b1;
          bad_d   = dec.undef;
        end else begin
          mem_rd = 1'b1;
          pc_d   = pc_q + {{(AW-1){1'b0}}, 1'b1};
          pc_en  = 1'b1;
        end
      end
      S_OPD1: begin
        case (dec.mode)
          M_IMM: exec_en = 1'b1;
          M_REL: begin
            pc_d  = pc_q + {{PAGE_W{mem_rdata[DW-1]}}, mem_rdata};
            pc_en = 1'b1;
          end
          M_DIR: begin
            mem_addr = {{PAGE_W{1'b0}}, mem_rdata};
            mem_rd   = 1'b1;
          end
          M_EXT: begin
            hi_en  = 1'b1;
            mem_rd = 1'b1;
            pc_d   = pc_q + {{(AW-1){1'b0}}, 1'b1};
            pc_en  = 1'b1;
          end
          default: ;
        endcase
      end
      S_OPD2: begin
        mem_addr = {hi_q, mem_rdata};
        if (dec.op == A_STA) mem_wr = 1'b1;
        else                 mem_rd = 1'b1;
      end
      S_EXEC: exec_en = 1'b1;
      default: ;
    endcase
  end

  assign a_en    = exec_en && (dec.op == A_CLRA || dec.op == A_LDA ||
                               dec.op == A_ADDA || dec.op == A_SUBA);
  assign b_en    = exec_en && (dec.op == A_INCB);
  assign flag_en = a_en || b_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      hi_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      if (pc_en)   pc_q <= pc_d;
      if (ir_en)   ir_q <= mem_rdata;
      if (hi_en)   hi_q <= mem_rdata;
      if (a_en)    a_q  <= alu_res;
      if (b_en)    b_q  <= alu_res;
      if (flag_en) begin
        z_q <= alu_z;
        c_q <= alu_c;
      end
      bad_q <= bad_d;
    end
  end

  assign mem_wdata  = a_q;
  assign acc_a      = a_q;
  assign acc_b      = b_q;
  assign zero_flag  = z_q;
  assign carry_flag = c_q;
  assign bad_opcode = bad_q;

endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk
  import acc_seq_pkg::*;
(
  input logic          clk,
  input logic          rst_int_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          zero_flag,
  input logic          carry_flag,
  input logic          bad_opcode,
  input seq_state_t    state_q,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] ir_q
);

  // R1
  boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_BOOT) |-> (!mem_rd && !mem_wr));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_FETCH) |=> (pc_q == $past(pc_q) + {{(AW-1){1'b0}}, 1'b1}));

  // R7
  zero_page_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_OPD1 && ir_q == OPC_ADDA_DIR) |-> (mem_rd && mem_addr[AW-1:DW] == '0));

  // R9
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_rd && mem_wr));

  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |=> !mem_wr);

  // R10
  branch_len_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_OPD1 && ir_q == OPC_BRA) |=> (state_q == S_FETCH));

  // R11
  bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    bad_opcode |=> !bad_opcode);

  // R12
  store_flags_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |=> ($stable(zero_flag) && $stable(carry_flag)));

endmodule

bind acc_seq_core acc_seq_core_chk u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_addr   (mem_addr),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag),
  .bad_opcode (bad_opcode),
  .state_q    (state_q),
  .pc_q       (pc_q),
  .ir_q       (ir_q)
);

// File: tb/acc_seq_core_bench.sv
module acc_seq_core_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] boot_addr;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  acc_a, acc_b;
  logic        zero_flag, carry_flag, bad_opcode;

  acc_seq_core u_acc_seq_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_addr  (boot_addr),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .acc_a      (acc_a),
    .acc_b      (acc_b),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .bad_opcode (bad_opcode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: 4 KiB aliased, one-cycle read latency, plus monitors
  logic [7:0]  mem [0:4095];
  logic        mem_clr, ld_en, log_clr;
  logic [15:0] ld_addr;
  logic [7:0]  ld_data;
  logic [15:0] rd_log [0:63];
  int          log_n, wr_n, bad_cycles;

  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
    end else if (ld_en) begin
      mem[ld_addr[11:0]] <= ld_data;
    end else if (mem_wr) begin
      mem[mem_addr[11:0]] <= mem_wdata;
    end
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (log_clr) begin
      log_n      <= 0;
      wr_n       <= 0;
      bad_cycles <= 0;
    end else begin
      if (mem_rd && log_n < 64) begin
        rd_log[log_n] <= mem_addr;
        log_n <= log_n + 1;
      end
      if (mem_wr) wr_n <= wr_n + 1;
      if (bad_opcode) bad_cycles <= bad_cycles + 1;
    end
  end

  int checks, errors;
  logic [15:0] wp;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    ld_en = 1'b1; ld_addr = wp; ld_data = b;
    @(negedge clk);
    ld_en = 1'b0;
    wp = wp + 16'd1;
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] b);
    wp = a;
    emit(b);
  endtask

  // hold reset, wipe memory, leave wp at start
  task automatic prep(input logic [15:0] start);
    @(negedge clk);
    rst_n = 1'b0;
    boot_addr = start;
    mem_clr = 1'b1;
    @(negedge clk);
    mem_clr = 1'b0;
    wp = start;
  endtask

  task automatic go(input int cycles);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  // R3 R12: inherent clear and increment
  task automatic t_inherent();
    prep(16'h0800);
    emit(8'h86); emit(8'h6A);
    emit(8'h5C); emit(8'h5C);
    emit(8'h4F);
    emit(8'hB7); emit(8'h03); emit(8'h10);
    emit(8'h20); emit(8'hFE);
    poke(16'h0310, 8'hEE);
    go(60);
    chk("R3 clear A", acc_a, 8'h00);
    chk("R3 incr B twice", acc_b, 8'h02);
    chk("R12 zero after clear", zero_flag, 1);
    chk("R12 carry after clear", carry_flag, 0);
    chk("R9 stored cleared A", mem[12'h310], 8'h00);
  endtask

  // R5 R6 R4: immediate arithmetic and flags
  task automatic t_arith();
    prep(16'h0800);
    emit(8'h86); emit(8'hF0);
    emit(8'h8B); emit(8'h20);
    emit(8'h20); emit(8'hFE);
    go(40);
    chk("R5 add imm result", acc_a, 8'h10);
    chk("R5 add carry out", carry_flag, 1);
    chk("R5 add zero", zero_flag, 0);

    prep(16'h0800);
    emit(8'h86); emit(8'h10);
    emit(8'h80); emit(8'h11);
    emit(8'h20); emit(8'hFE);
    go(40);
    chk("R6 sub result", acc_a, 8'hFF);
    chk("R6 sub borrow", carry_flag, 1);
    chk("R6 sub zero", zero_flag, 0);

    prep(16'h0800);
    emit(8'h86); emit(8'hFF);
    emit(8'h80); emit(8'hFF);
    emit(8'hB7); emit(8'h03); emit(8'h02);
    emit(8'h20); emit(8'hFE);
    poke(16'h0302, 8'h5A);
    go(40);
    chk("R6 sub to zero", acc_a, 8'h00);
    chk("R6 no borrow", carry_flag, 0);
    chk("R12 zero set by sub, kept by store", zero_flag, 1);
    chk("R9 stored value", mem[12'h302], 8'h00);
  endtask

  // R2 R7 R8 R4 R9: addressing modes and the read sequence
  task automatic t_modes();
    logic [15:0] exp_log [22];
    prep(16'h0800);
    emit(8'h86); emit(8'h01);
    emit(8'h9B); emit(8'h42);
    emit(8'hBB); emit(8'h12); emit(8'h42);
    emit(8'hB7); emit(8'h00); emit(8'h50);
    emit(8'h8B); emit(8'hF0);
    emit(8'hB6); emit(8'h12); emit(8'h42);
    emit(8'h20); emit(8'hFE);
    poke(16'h0042, 8'h05);
    poke(16'h1242, 8'h30);
    go(80);
    exp_log = '{16'h0800, 16'h0801, 16'h0802, 16'h0803, 16'h0042,
                16'h0804, 16'h0805, 16'h0806, 16'h1242,
                16'h0807, 16'h0808, 16'h0809,
                16'h080A, 16'h080B,
                16'h080C, 16'h080D, 16'h080E, 16'h1242,
                16'h080F, 16'h0810, 16'h080F, 16'h0810};
    for (int i = 0; i < 22; i++) begin
      if (i == 4) chk("R7 zero-page read address", rd_log[i], exp_log[i]);
      else if (i == 8 || i == 17) chk("R8 extended read address", rd_log[i], exp_log[i]);
      else chk("R2 stream read address", rd_log[i], exp_log[i]);
    end
    chk("R9 stored A after dir and ext adds", mem[12'h050], 8'h36);
    chk("R9 single write pulse", wr_n, 1);
    chk("R4 extended load", acc_a, 8'h30);
    chk("R4 load clears carry", carry_flag, 0);
  endtask

  // R10: forward skip and self loop
  task automatic t_branch();
    prep(16'h0800);
    emit(8'h20); emit(8'h02);
    emit(8'h86); emit(8'hAA);
    emit(8'h86); emit(8'h55);
    emit(8'hB7); emit(8'h02); emit(8'h00);
    emit(8'h20); emit(8'hFE);
    go(60);
    chk("R10 target after offset byte", rd_log[2], 16'h0804);
    chk("R10 skipped load", acc_a, 8'h55);
    chk("R10 store after branch", mem[12'h200], 8'h55);
    chk("R10 self loop opcode", rd_log[9], 16'h0809);
    chk("R10 self loop repeat", rd_log[11], 16'h0809);
  endtask

  // R11: undefined opcode
  task automatic t_undef();
    prep(16'h0800);
    emit(8'h86); emit(8'h77);
    emit(8'h01);
    emit(8'hB7); emit(8'h03); emit(8'h20);
    emit(8'h20); emit(8'hFE);
    go(50);
    chk("R11 one byte consumed", rd_log[3], 16'h0803);
    chk("R11 pulse one cycle", bad_cycles, 1);
    chk("R11 A untouched", mem[12'h320], 8'h77);
    chk("R11 flags untouched", zero_flag, 0);
  endtask

  // R12 R3: B wraps with carry
  task automatic t_wrap();
    prep(16'h0400);
    for (int i = 0; i < 256; i++) emit(8'h5C);
    emit(8'h20); emit(8'hFE);
    go(560);
    chk("R1 first read at boot address", rd_log[0], 16'h0400);
    chk("R12 B wrapped", acc_b, 8'h00);
    chk("R12 wrap carry", carry_flag, 1);
    chk("R12 wrap zero", zero_flag, 1);
    chk("R3 A untouched", acc_a, 8'h00);
  endtask

  // R1: reset state and restart address
  task automatic t_reset();
    prep(16'h0800);
    emit(8'h86); emit(8'h80);
    emit(8'h5C);
    emit(8'h20); emit(8'hFE);
    go(30);
    @(negedge clk);
    rst_n = 1'b0;
    boot_addr = 16'h0A5C;
    @(negedge clk);
    chk("R1 reset rd", mem_rd, 0);
    chk("R1 reset wr", mem_wr, 0);
    chk("R1 reset A", acc_a, 8'h00);
    chk("R1 reset B", acc_b, 8'h00);
    chk("R1 reset flags", {zero_flag, carry_flag}, 0);
    go(12);
    chk("R1 restart read", rd_log[0], 16'h0A5C);
    chk("R1 restart next", rd_log[1], 16'h0A5D);
  endtask

  logic wd_hit;

  initial begin
    checks = 0; errors = 0; wd_hit = 1'b0;
    rst_n = 1'b0; boot_addr = 16'h0000;
    mem_clr = 1'b0; ld_en = 1'b0; log_clr = 1'b1;
    ld_addr = '0; ld_data = '0; wp = '0;
    fork
      begin
        repeat (2) @(negedge clk);
        t_inherent();
        t_arith();
        t_modes();
        t_branch();
        t_undef();
        t_wrap();
        t_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule